// File: doc/BRIEF.md
# Inbound Write Flow Controller

This block is the target-side decision logic for write bursts that arrive from a graphics port and go into memory. In every cycle of an active frame it chooses one of four responses to the initiator: it accepts the data phase, inserts a wait state, retries the transaction, or disconnects it. The inputs are a full flag from the inbound write buffer, a pending non-snoopable request from the port, and a pending host request for ownership of the port. The buffer, the memory path and the arbiter that raises the two request flags are outside this block.

The response depends on whether data has already moved in the current frame. Before the first transfer, a full buffer leads to a retry if either priority request is pending. Otherwise it leads to wait states, and these turn into a retry as soon as a priority request appears. After the first transfer a retry is no longer allowed. A full buffer then gives wait states, and these end in a disconnect after a bounded number of full-while-priority cycles. The controller also tracks the burst address and disconnects the burst when it would step into a new page. Page size, bytes per data phase and the disconnect bound are parameters. The defaults are a 2 KB page, 8-byte phases and 8 clocks.

Top module: `inbound_wr_flow_ctl`

## Requirements
- R1: While `rstN` is low and after its release, all four strobes are low when `frameActive` is low. The first frame after reset is treated as a fresh transaction.
- R2: No strobe is asserted in a cycle with `frameActive` low. At most one of `accept`, `waitState`, `retry`, `disconnect` is high in any cycle.
- R3: In the first phase of a frame, with `bufFull` high and `nsReq` or `hostReq` high, `retry` is asserted in that same cycle.
- R4: In the first phase of a frame, with `bufFull` high and both `nsReq` and `hostReq` low, `waitState` is asserted.
- R5: While wait states are inserted before any transfer, `retry` is asserted in the first cycle in which `nsReq` or `hostReq` is high, if the buffer is still full.
- R6: While wait states are inserted before any transfer, `accept` is asserted in the first cycle with `bufFull` low, whether or not a priority request is pending.
- R7: A phase with `bufFull` low is accepted, and `addrIn` is taken as the burst address in the first cycle of the frame. Each accepted phase advances the address by STEP_BYTES.
- R8: After the first transfer, consecutive cycles of full-with-priority give `waitState` for DISC_CLKS-1 cycles and then `disconnect` on cycle DISC_CLKS. The count is cleared by any cycle with `bufFull` low.
- R9: After the first transfer, a full buffer with no priority request gives `waitState` for as long as it lasts, and those cycles leave the disconnect count unchanged.
- R10: When the next phase's address is a multiple of PAGE_BYTES and at least one phase has been accepted, that phase gets `disconnect` instead of `accept`. This boundary disconnect wins over a full buffer.
- R11: `retry` is never asserted after a phase of the same frame has been accepted. Later terminations are disconnects.
- R12: After `retry` or `disconnect`, no strobe is asserted until `frameActive` has gone low. A new frame then starts fresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameActive | input | 1 | High for every cycle of an inbound write frame; each such cycle is a data phase offer |
| addrIn | input | ADDR_W | Start byte address, sampled in the first cycle of a frame |
| bufFull | input | 1 | Inbound write buffer has no room this cycle |
| nsReq | input | 1 | Non-snoopable port request pending |
| hostReq | input | 1 | Host request for port ownership pending |
| accept | output | 1 | Current data phase is taken |
| waitState | output | 1 | Current data phase is stalled |
| retry | output | 1 | Transaction retried before any transfer |
| disconnect | output | 1 | Burst terminated after at least one transfer |

## Verification
The bench builds the block with a 64-byte page, 4-byte phases and a disconnect bound of 3. With these values a page holds 16 phases, so the bench can sweep every starting slot in a page and count accepted phases up to the boundary disconnect. It also runs every priority combination at the first phase, with a full buffer and with a draining buffer. The short bound makes the window tests small: counter clear, counter hold while priority is absent, and boundary-over-full precedence.

// File: rtl/iwfc_pkg.sv
package iwfc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACCEPT,
    ST_WAIT,
    ST_RETRY,
    ST_DISC
  } iwfcState_t;

  // Strobes from control to datapath; all take effect at the next edge.
  typedef struct packed {
    logic load;     // capture start address
    logic advance;  // step address by one phase
    logic cntClr;   // clear full-while-priority count
    logic cntInc;   // bump full-while-priority count
  } iwfcStrobe_t;

endpackage

// File: rtl/iwfc_datapath.sv
module iwfc_datapath #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_BYTES = 2048,
  parameter int STEP_BYTES = 8,
  parameter int DISC_CLKS  = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      addrIn,
  input  iwfc_pkg::iwfcStrobe_t  strobe,
  output logic                   atPageStart,
  output logic                   cntAtLimit
);

  localparam int PAGE_BITS = $clog2(PAGE_BYTES);
  localparam int CNT_W     = $clog2(DISC_CLKS) + 1;
  localparam logic [ADDR_W-1:0] STEP_V  = ADDR_W'(STEP_BYTES);
  localparam logic [CNT_W-1:0]  LIMIT_V = CNT_W'(DISC_CLKS - 1);

  logic [ADDR_W-1:0] addrReg;
  logic [ADDR_W-1:0] addrBase;
  logic [CNT_W-1:0]  stallCnt;

  // Address of the next phase: base is the new start on load.
  assign addrBase = strobe.load ? addrIn : addrReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
    end else if (strobe.load || strobe.advance) begin
      addrReg <= addrBase + (strobe.advance ? STEP_V : '0);
    end
  end

  assign atPageStart = (addrReg[PAGE_BITS-1:0] == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stallCnt <= '0;
    end else if (strobe.cntClr) begin
      stallCnt <= '0;
    end else if (strobe.cntInc && (stallCnt != LIMIT_V)) begin
      stallCnt <= stallCnt + 1'b1;
    end
  end

  assign cntAtLimit = (stallCnt == LIMIT_V);

endmodule

// File: rtl/iwfc_control.sv
module iwfc_control (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   frameActive,
  input  logic                   bufFull,
  input  logic                   nsReq,
  input  logic                   hostReq,
  input  logic                   atPageStart,
  input  logic                   cntAtLimit,
  output iwfc_pkg::iwfcStrobe_t  strobe,
  output logic                   accept,
  output logic                   waitState,
  output logic                   retry,
  output logic                   disconnect
);

  import iwfc_pkg::*;

  iwfcState_t state, stateNext;
  logic prio;

  assign prio = nsReq | hostReq;

  always_comb begin
    accept     = 1'b0;
    waitState  = 1'b0;
    retry      = 1'b0;
    disconnect = 1'b0;
    strobe     = '0;
    strobe.cntClr = (state == ST_IDLE) | ~bufFull;

    unique case (state)
      ST_IDLE, ST_WAIT: begin
        if (frameActive) begin
          strobe.load = (state == ST_IDLE);
          if (bufFull && prio) begin
            retry = 1'b1;
          end else if (bufFull) begin
            waitState = 1'b1;
          end else begin
            accept         = 1'b1;
            strobe.advance = 1'b1;
          end
        end
      end
      ST_ACCEPT: begin
        if (frameActive) begin
          if (atPageStart) begin
            disconnect = 1'b1;
          end else if (bufFull) begin
            if (prio && cntAtLimit) begin
              disconnect = 1'b1;
            end else begin
              waitState     = 1'b1;
              strobe.cntInc = prio;
            end
          end else begin
            accept         = 1'b1;
            strobe.advance = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_comb begin
    stateNext = state;
    if (!frameActive) begin
      stateNext = ST_IDLE;
    end else if (retry) begin
      stateNext = ST_RETRY;
    end else if (disconnect) begin
      stateNext = ST_DISC;
    end else if (accept) begin
      stateNext = ST_ACCEPT;
    end else if (waitState && (state == ST_IDLE)) begin
      stateNext = ST_WAIT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/inbound_wr_flow_ctl.sv
module inbound_wr_flow_ctl #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_BYTES = 2048,
  parameter int STEP_BYTES = 8,
  parameter int DISC_CLKS  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameActive,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              bufFull,
  input  logic              nsReq,
  input  logic              hostReq,
  output logic              accept,
  output logic              waitState,
  output logic              retry,
  output logic              disconnect
);

  iwfc_pkg::iwfcStrobe_t strobe;
  logic atPageStart;
  logic cntAtLimit;

  iwfc_control u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .frameActive (frameActive),
    .bufFull     (bufFull),
    .nsReq       (nsReq),
    .hostReq     (hostReq),
    .atPageStart (atPageStart),
    .cntAtLimit  (cntAtLimit),
    .strobe      (strobe),
    .accept      (accept),
    .waitState   (waitState),
    .retry       (retry),
    .disconnect  (disconnect)
  );

  iwfc_datapath #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES),
    .STEP_BYTES (STEP_BYTES),
    .DISC_CLKS  (DISC_CLKS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .addrIn      (addrIn),
    .strobe      (strobe),
    .atPageStart (atPageStart),
    .cntAtLimit  (cntAtLimit)
  );

endmodule

// File: rtl/inbound_wr_flow_ctl_chk.sv
module inbound_wr_flow_ctl_chk (
  input logic clk,
  input logic rstN,
  input logic frameActive,
  input logic bufFull,
  input logic nsReq,
  input logic hostReq,
  input logic accept,
  input logic waitState,
  input logic retry,
  input logic disconnect
);

  logic sawAcc;
  logic termd;
  logic anyStrobe;

  assign anyStrobe = accept | waitState | retry | disconnect;

  always_ff @(posedge clk) begin
    if (!rstN || !frameActive) begin
      sawAcc <= 1'b0;
      termd  <= 1'b0;
    end else begin
      if (accept)              sawAcc <= 1'b1;
      if (retry || disconnect) termd  <= 1'b1;
    end
  end

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({accept, waitState, retry, disconnect}));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !frameActive |-> !anyStrobe);

  p_first_full_prio_r3: assert property (@(posedge clk) disable iff (!rstN)
    (frameActive && !sawAcc && !termd && bufFull && (nsReq || hostReq)) |-> retry);

  p_first_full_wait_r4: assert property (@(posedge clk) disable iff (!rstN)
    (frameActive && !sawAcc && !termd && bufFull && !nsReq && !hostReq) |-> waitState);

  p_first_room_accept_r6: assert property (@(posedge clk) disable iff (!rstN)
    (frameActive && !sawAcc && !termd && !bufFull) |-> accept);

  p_accept_room_r7: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> !bufFull);

  p_no_late_retry_r11: assert property (@(posedge clk) disable iff (!rstN)
    sawAcc |-> !retry);

  p_silent_after_term_r12: assert property (@(posedge clk) disable iff (!rstN)
    termd |-> !anyStrobe);

endmodule

bind inbound_wr_flow_ctl inbound_wr_flow_ctl_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .frameActive (frameActive),
  .bufFull     (bufFull),
  .nsReq       (nsReq),
  .hostReq     (hostReq),
  .accept      (accept),
  .waitState   (waitState),
  .retry       (retry),
  .disconnect  (disconnect)
);

// File: tb/inbound_wr_flow_ctl_test.sv
`timescale 1ns/1ps
module inbound_wr_flow_ctl_test;

  localparam int AW     = 16;
  localparam int PAGE   = 64;
  localparam int STEP   = 4;
  localparam int DCLK   = 3;
  localparam int PHASES = PAGE / STEP;
  localparam logic [AW-1:0] BASE = 16'h1240;

  localparam int C_NONE = 0, C_ACC = 1, C_WAIT = 2, C_RTY = 3, C_DISC = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameActive = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic bufFull = 1'b0, nsReq = 1'b0, hostReq = 1'b0;
  logic accept, waitState, retry, disconnect;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  inbound_wr_flow_ctl #(
    .ADDR_W(AW), .PAGE_BYTES(PAGE), .STEP_BYTES(STEP), .DISC_CLKS(DCLK)
  ) uut (
    .clk(clk), .rstN(rstN), .frameActive(frameActive), .addrIn(addrIn),
    .bufFull(bufFull), .nsReq(nsReq), .hostReq(hostReq),
    .accept(accept), .waitState(waitState), .retry(retry), .disconnect(disconnect)
  );

  function automatic int outCode();
    int n;
    n = int'(accept) + int'(waitState) + int'(retry) + int'(disconnect);
    if (n > 1)      return 9;
    if (accept)     return C_ACC;
    if (waitState)  return C_WAIT;
    if (retry)      return C_RTY;
    if (disconnect) return C_DISC;
    return C_NONE;
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    nRun++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // One cycle: drive at falling edge, sample strobes before rising edge.
  task automatic phase(input bit fr, input bit full, input bit ns, input bit host,
                       input logic [AW-1:0] a, input int exp, input string req);
    @(negedge clk);
    frameActive = fr; bufFull = full; nsReq = ns; hostReq = host; addrIn = a;
    #1;
    chk(req, outCode(), exp);
  endtask

  task automatic idleCycle();
    phase(1'b0, 1'b0, 1'b0, 1'b0, '0, C_NONE, "R2");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nFail++;
      nRun++;
      $display("FAIL watchdog: got hang expected finish");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    // R1: quiet during reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk("R1", outCode(), C_NONE);
    end
    @(negedge clk); rstN = 1'b1;
    idleCycle();
    // R1/R7: fresh first frame after reset accepts
    phase(1, 0, 0, 0, BASE, C_ACC, "R1");
    idleCycle();

    // R2: idle inputs cause nothing
    phase(0, 1, 1, 1, BASE, C_NONE, "R2");
    phase(0, 1, 0, 0, BASE, C_NONE, "R2");

    // R10/R7: sweep every start slot; accepts = PHASES - slot
    for (int s = 0; s < PHASES; s++) begin
      logic [AW-1:0] a;
      a = BASE + AW'(s * STEP);
      for (int k = 0; k < PHASES - s; k++)
        phase(1, 0, 0, 0, (k == 0) ? a : 16'hFFFF, C_ACC, "R7");
      phase(1, 0, 0, 0, 16'hFFFF, C_DISC, "R10");
      phase(1, 0, 0, 0, 16'hFFFF, C_NONE, "R12");
      idleCycle();
    end

    // R3/R4: all priority combinations with full buffer at first phase
    for (int p = 0; p < 4; p++) begin
      phase(1, 1, p[0], p[1], BASE, (p != 0) ? C_RTY : C_WAIT, (p != 0) ? "R3" : "R4");
      idleCycle();
    end

    // R5/R6: leave wait state in four ways
    for (int v = 0; v < 4; v++) begin
      phase(1, 1, 0, 0, BASE, C_WAIT, "R4");
      phase(1, 1, 0, 0, BASE, C_WAIT, "R4");
      case (v)
        0: phase(1, 1, 1, 0, BASE, C_RTY, "R5");
        1: phase(1, 1, 0, 1, BASE, C_RTY, "R5");
        2: phase(1, 0, 0, 0, BASE, C_ACC, "R6");
        default: phase(1, 0, 1, 1, BASE, C_ACC, "R6");
      endcase
      phase(1, 0, 0, 0, BASE, (v < 2) ? C_NONE : C_ACC, (v < 2) ? "R12" : "R7");
      idleCycle();
    end

    // R8: bounded stall ends in disconnect
    phase(1, 0, 0, 0, BASE, C_ACC, "R7");
    phase(1, 0, 0, 0, BASE, C_ACC, "R7");
    for (int i = 0; i < DCLK - 1; i++) phase(1, 1, 1, 0, BASE, C_WAIT, "R8");
    phase(1, 1, 1, 0, BASE, C_DISC, "R8");
    phase(1, 1, 1, 0, BASE, C_NONE, "R12");
    idleCycle();

    // R8: drain clears the count
    phase(1, 0, 0, 0, BASE, C_ACC, "R7");
    for (int i = 0; i < DCLK - 1; i++) phase(1, 1, 0, 1, BASE, C_WAIT, "R8");
    phase(1, 0, 0, 1, BASE, C_ACC, "R8");
    for (int i = 0; i < DCLK - 1; i++) phase(1, 1, 0, 1, BASE, C_WAIT, "R8");
    phase(1, 1, 0, 1, BASE, C_DISC, "R8");
    idleCycle();

    // R9: full without priority holds count
    phase(1, 0, 0, 0, BASE, C_ACC, "R7");
    phase(1, 1, 1, 0, BASE, C_WAIT, "R8");
    for (int i = 0; i < 10; i++) phase(1, 1, 0, 0, BASE, C_WAIT, "R9");
    for (int i = 1; i < DCLK - 1; i++) phase(1, 1, 1, 0, BASE, C_WAIT, "R9");
    phase(1, 1, 1, 0, BASE, C_DISC, "R9");
    idleCycle();

    // R10: boundary wins over full buffer
    phase(1, 0, 0, 0, BASE + AW'((PHASES - 1) * STEP), C_ACC, "R7");
    phase(1, 1, 1, 0, BASE, C_DISC, "R10");
    idleCycle();
    phase(1, 0, 0, 0, BASE + AW'((PHASES - 1) * STEP), C_ACC, "R7");
    phase(1, 1, 0, 0, BASE, C_DISC, "R10");
    idleCycle();

    // R11: full+priority after a transfer waits, never retries
    phase(1, 0, 0, 0, BASE, C_ACC, "R7");
    phase(1, 1, 1, 1, BASE, C_WAIT, "R11");
    idleCycle();
    // R12: new frame after termination starts fresh
    phase(1, 1, 1, 1, BASE, C_RTY, "R12");
    idleCycle();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule